// File: doc/BRIEF.md
# Emulation Visibility Bus Multiplexer

This block turns a stream of per-bus-cycle access descriptors into a time-multiplexed trace on a set of shared external pins. It produces its own bus clock at half the rate of the core clock. While that bus clock is high the pins carry the access address. While it is low they carry the internal read data, and two side fields carry the access-source code and the instruction queue status. An external emulator or logic analyser captures both phases to rebuild what happened on the internal bus.

Each access is spread over bus cycles. The source code appears in the low phase of the access's first cycle. The queue status and, for CPU reads, the read data appear in the low phase of the following cycle. A stretched access keeps sending descriptors with a continue flag set, and the block then shows explicit null patterns. The descriptor stream is valid/ready. `acc_ready` is high only while the bus clock is low, which is the core-clock cycle before a new bus cycle starts. A descriptor moves on the rising core-clock edge where `acc_valid` and `acc_ready` are both high. The producer must hold its descriptor stable until it is taken. A bus cycle that starts with no descriptor taken is an idle cycle. The queue status and read data are sampled with the descriptor.

Top module: `evis_mux`

## Requirements
- R1: `trc_eclk` toggles on every core-clock edge, so one bus cycle is two core cycles, high phase first. It is low while reset is held.
- R2: During the high phase `trc_pins` carries the address of the descriptor taken at the start of that bus cycle. In an idle cycle it repeats the most recent taken address, which is 0 after reset.
- R3: During the low phase `trc_src` shows 100 in an idle cycle. It shows the descriptor's `acc_src` code in the first cycle of an access, and 000 in a continuation cycle. Source codes: 001 CPU, 010 debug external, 011 coprocessor, 101 CPU error.
- R4: During the low phase `trc_qs` shows the status captured with the previous cycle's descriptor when the previous cycle was the first cycle of an access. Otherwise it shows 0000. This covers idle cycles, the third and later cycles of a stretched access, and the cycle after a stretched access ends.
- R5: For a CPU (001) read, the low phase of the next cycle shows data on the pins. `rd_data` holds {byte at addr, byte at addr+1}. An even word read shows `rd_data` as is. An odd word read shows its two bytes swapped. A byte read takes the byte from `rd_data[7:0]`: an even address puts it on pins[15:8] and an odd address on pins[7:0]. The other lane keeps the address byte from the high phase.
- R6: In all other cases the low-phase pins keep the high-phase address. This covers reads from any other source, writes, idle cycles and the low phase of the first cycle.
- R7: With `acc_fw` set, `trc_rnw` reads 1 even for a write, and the status shown in the next cycle is 0000.
- R8: `acc_ready` is low during the high phase. A descriptor offered then is not taken until the next low phase.
- R9: A descriptor with `acc_cont` set that follows an idle cycle is treated as the first cycle of a new access.
- R10: Synchronous reset sets `trc_pins` to 0, `trc_src` to 100, `trc_qs` to 0000 and `trc_rnw` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous reset, active high |
| acc_valid | input | 1 | descriptor offered |
| acc_ready | output | 1 | descriptor can be taken this edge |
| acc_cont | input | 1 | continuation of the previous cycle's access |
| acc_src | input | 3 | access-source code |
| acc_addr | input | 16 | access address |
| acc_word | input | 1 | 1 word access, 0 byte access |
| acc_rd | input | 1 | 1 read, 0 write |
| acc_fw | input | 1 | access to debug firmware or debug registers |
| cpu_qs | input | 4 | instruction queue status for this access |
| rd_data | input | 16 | internal read data, {byte at addr, byte at addr+1} |
| trc_eclk | output | 1 | bus clock |
| trc_pins | output | 16 | multiplexed address / data pins |
| trc_src | output | 3 | access-source field, low phase |
| trc_qs | output | 4 | queue status field, low phase |
| trc_rnw | output | 1 | read/write indication, high phase |

## Verification
The hardest situation to reach is a stretched access. Its three null patterns fall in different cycles: the source field in cycle two, the status in cycle three, and the status again in the first cycle after the access ends. Each of these has to be seen apart from idle cycles. The bench sends a three-cycle misaligned word read with the continue flag set on its second and third descriptors. It then checks every phase of all four bus cycles, so the swapped data lanes and each null pattern are pinned to one exact cycle. A continue flag after an idle cycle is covered by a separate directed sequence.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int SRC_W = 3;
  localparam int QS_W  = 4;

  localparam logic [SRC_W-1:0] SRC_REPEAT = 3'b000;
  localparam logic [SRC_W-1:0] SRC_CPU    = 3'b001;
  localparam logic [SRC_W-1:0] SRC_IDLE   = 3'b100;

  // control information kept for one bus cycle
  typedef struct packed {
    logic             act;
    logic             first;
    logic [SRC_W-1:0] src;
    logic [QS_W-1:0]  iq;
    logic             rd;
    logic             word;
    logic             a0;
    logic             fw;
  } cyc_t;
endpackage

// File: rtl/evm_phase.sv
module evm_phase (
  input  logic clk,
  input  logic rst,
  output logic eclk,
  output logic load_hi,
  output logic load_lo
);
  logic eclk_q;

  always_ff @(posedge clk) begin
    if (rst) eclk_q <= 1'b0;
    else     eclk_q <= ~eclk_q;
  end

  assign eclk    = eclk_q;
  assign load_hi = ~eclk_q;  // next edge opens a bus cycle
  assign load_lo = eclk_q;   // next edge opens the low phase

  p_eclk_fall_r1: assert property (@(posedge clk) disable iff (rst)
    eclk_q |=> !eclk_q);
  p_eclk_rise_r1: assert property (@(posedge clk) disable iff (rst)
    !eclk_q |=> eclk_q);
endmodule

// File: rtl/evm_track.sv
module evm_track
  import evm_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_hi,
  input  logic             fire,
  input  logic             acc_cont,
  input  logic [SRC_W-1:0] acc_src,
  input  logic [PIN_W-1:0] acc_addr,
  input  logic             acc_word,
  input  logic             acc_rd,
  input  logic             acc_fw,
  input  logic [QS_W-1:0]  cpu_qs,
  input  logic [PIN_W-1:0] rd_data,
  output cyc_t             cur,
  output cyc_t             prev,
  output logic [PIN_W-1:0] prev_data,
  output logic [PIN_W-1:0] addr_q
);
  cyc_t             nxt;
  logic [PIN_W-1:0] cur_data;

  always_comb begin
    nxt       = '0;
    nxt.act   = fire;
    nxt.first = fire && !(acc_cont && cur.act);
    nxt.src   = acc_src;
    nxt.iq    = cpu_qs;
    nxt.rd    = acc_rd;
    nxt.word  = acc_word;
    nxt.a0    = acc_addr[0];
    nxt.fw    = acc_fw;
    if (!fire) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      prev      <= '0;
      cur_data  <= '0;
      prev_data <= '0;
      addr_q    <= '0;
    end else if (load_hi) begin
      prev      <= cur;
      prev_data <= cur_data;
      cur       <= nxt;
      if (fire) begin
        cur_data <= rd_data;
        addr_q   <= acc_addr;
      end
    end
  end

  p_first_after_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (load_hi && fire && acc_cont && !cur.act) |=> cur.first);
endmodule

// File: rtl/evm_lanes.sv
module evm_lanes
  import evm_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  cyc_t             prev,
  input  logic [PIN_W-1:0] prev_data,
  input  logic [PIN_W-1:0] held,
  output logic             show,
  output logic [PIN_W-1:0] lanes
);
  localparam int LANE_W = PIN_W / 2;

  logic [LANE_W-1:0] d_hi, d_lo;

  assign d_hi = prev_data[PIN_W-1:LANE_W];
  assign d_lo = prev_data[LANE_W-1:0];
  assign show = prev.act && prev.first && prev.rd && (prev.src == SRC_CPU);

  always_comb begin
    unique case ({prev.word, prev.a0})
      2'b10:   lanes = prev_data;
      2'b11:   lanes = {d_lo, d_hi};
      2'b00:   lanes = {d_lo, held[LANE_W-1:0]};
      default: lanes = {held[PIN_W-1:LANE_W], d_lo};
    endcase
  end
endmodule

// File: rtl/evis_mux.sv
module evis_mux
  import evm_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_cont,
  input  logic [SRC_W-1:0] acc_src,
  input  logic [PIN_W-1:0] acc_addr,
  input  logic             acc_word,
  input  logic             acc_rd,
  input  logic             acc_fw,
  input  logic [QS_W-1:0]  cpu_qs,
  input  logic [PIN_W-1:0] rd_data,
  output logic             trc_eclk,
  output logic [PIN_W-1:0] trc_pins,
  output logic [SRC_W-1:0] trc_src,
  output logic [QS_W-1:0]  trc_qs,
  output logic             trc_rnw
);
  logic             eclk, load_hi, load_lo, fire, show;
  cyc_t             cur, prev;
  logic [PIN_W-1:0] prev_data, addr_q, lanes;
  logic [PIN_W-1:0] pins_q;
  logic [SRC_W-1:0] src_q;
  logic [QS_W-1:0]  qs_q;
  logic             rnw_q;

  evm_phase u_phase (
    .clk(clk), .rst(rst), .eclk(eclk), .load_hi(load_hi), .load_lo(load_lo)
  );

  assign acc_ready = load_hi;
  assign fire      = acc_valid && load_hi;

  evm_track #(.PIN_W(PIN_W)) u_track (
    .clk(clk), .rst(rst), .load_hi(load_hi), .fire(fire),
    .acc_cont(acc_cont), .acc_src(acc_src), .acc_addr(acc_addr),
    .acc_word(acc_word), .acc_rd(acc_rd), .acc_fw(acc_fw),
    .cpu_qs(cpu_qs), .rd_data(rd_data),
    .cur(cur), .prev(prev), .prev_data(prev_data), .addr_q(addr_q)
  );

  evm_lanes #(.PIN_W(PIN_W)) u_lanes (
    .prev(prev), .prev_data(prev_data), .held(pins_q),
    .show(show), .lanes(lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      src_q  <= SRC_IDLE;
      qs_q   <= '0;
      rnw_q  <= 1'b1;
    end else if (load_hi) begin
      pins_q <= fire ? acc_addr : addr_q;
      rnw_q  <= fire ? (acc_rd || acc_fw) : 1'b1;
    end else if (load_lo) begin
      if (!cur.act)      src_q <= SRC_IDLE;
      else if (cur.first) src_q <= cur.src;
      else               src_q <= SRC_REPEAT;
      qs_q <= (prev.act && prev.first && !prev.fw) ? prev.iq : '0;
      if (show) pins_q <= lanes;
    end
  end

  assign trc_eclk = eclk;
  assign trc_pins = pins_q;
  assign trc_src  = src_q;
  assign trc_qs   = qs_q;
  assign trc_rnw  = rnw_q;

  p_addr_hi_r2: assert property (@(posedge clk) disable iff (rst)
    fire |=> (trc_pins == $past(acc_addr)));
  p_src_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !eclk |=> $stable(trc_src));
  p_src_cont_r3: assert property (@(posedge clk) disable iff (rst)
    (eclk && cur.act && !cur.first) |=> (trc_src == SRC_REPEAT));
  p_qs_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (eclk && !(prev.act && prev.first)) |=> (trc_qs == '0));
  p_rnw_fw_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && acc_fw) |=> trc_rnw);
  p_no_take_high_r8: assert property (@(posedge clk) disable iff (rst)
    (eclk && acc_valid) |=> $stable(cur));
endmodule

// File: tb/test_evis_mux.sv
module test_evis_mux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_ready, acc_cont = 1'b0;
  logic [2:0]  acc_src = '0;
  logic [15:0] acc_addr = '0;
  logic        acc_word = 1'b0, acc_rd = 1'b0, acc_fw = 1'b0;
  logic [3:0]  cpu_qs = '0;
  logic [15:0] rd_data = '0;
  logic        trc_eclk, trc_rnw;
  logic [15:0] trc_pins;
  logic [2:0]  trc_src;
  logic [3:0]  trc_qs;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evis_mux i_evis_mux (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_cont(acc_cont), .acc_src(acc_src), .acc_addr(acc_addr),
    .acc_word(acc_word), .acc_rd(acc_rd), .acc_fw(acc_fw),
    .cpu_qs(cpu_qs), .rd_data(rd_data), .trc_eclk(trc_eclk),
    .trc_pins(trc_pins), .trc_src(trc_src), .trc_qs(trc_qs), .trc_rnw(trc_rnw)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; entered and left at a falling core edge with eclk low
  task automatic bus_cyc(input bit v, input bit cont, input logic [2:0] s,
                         input logic [15:0] a, input bit word, input bit rd,
                         input bit fw, input logic [3:0] q, input logic [15:0] d,
                         input logic [15:0] e_hi, input bit e_rnw,
                         input logic [15:0] e_lo, input logic [2:0] e_src,
                         input logic [3:0] e_qs, input string tag);
    acc_valid = v; acc_cont = cont; acc_src = s; acc_addr = a;
    acc_word = word; acc_rd = rd; acc_fw = fw; cpu_qs = q; rd_data = d;
    @(negedge clk);
    chk({tag, " R1 eclk high"}, {15'd0, trc_eclk}, 16'd1);
    chk({tag, " R8 ready low in high phase"}, {15'd0, acc_ready}, 16'd0);
    chk({tag, " R2 high-phase pins"}, trc_pins, e_hi);
    chk({tag, " R7 rnw"}, {15'd0, trc_rnw}, {15'd0, e_rnw});
    acc_addr = 16'hDEAD;  // offered while not ready: must be ignored (R8)
    @(negedge clk);
    acc_valid = 1'b0;
    chk({tag, " R1 eclk low"}, {15'd0, trc_eclk}, 16'd0);
    chk({tag, " R5/R6 low-phase pins"}, trc_pins, e_lo);
    chk({tag, " R3 source"}, {13'd0, trc_src}, {13'd0, e_src});
    chk({tag, " R4 status"}, {12'd0, trc_qs}, {12'd0, e_qs});
  endtask

  task automatic idle(input logic [15:0] e_hi, input logic [15:0] e_lo,
                      input logic [3:0] e_qs, input string tag);
    bus_cyc(0, 0, 3'd0, 16'h0, 0, 0, 0, 4'h0, 16'h0, e_hi, 1, e_lo, 3'b100, e_qs, tag);
  endtask

  task automatic t_reset;
    chk("R10 pins", trc_pins, 16'h0);
    chk("R10 src", {13'd0, trc_src}, 16'h4);
    chk("R10 qs", {12'd0, trc_qs}, 16'h0);
    chk("R10 rnw", {15'd0, trc_rnw}, 16'h1);
    chk("R1 eclk low after reset", {15'd0, trc_eclk}, 16'h0);
  endtask

  task automatic t_word_even;  // R5 aligned word
    bus_cyc(1, 0, 3'b001, 16'h1234, 1, 1, 0, 4'h5, 16'hABCD, 16'h1234, 1, 16'h1234, 3'b001, 4'h0, "t1 c1");
    idle(16'h1234, 16'hABCD, 4'h5, "t1 c2");
    idle(16'h1234, 16'h1234, 4'h0, "t1 c3");
  endtask

  task automatic t_byte_odd_write;  // R5 odd byte, R6 write
    bus_cyc(1, 0, 3'b001, 16'h2001, 0, 1, 0, 4'h3, 16'h0077, 16'h2001, 1, 16'h2001, 3'b001, 4'h0, "t2 c1");
    bus_cyc(1, 0, 3'b001, 16'h3000, 1, 0, 0, 4'h9, 16'h0000, 16'h3000, 0, 16'h3077, 3'b001, 4'h3, "t2 c2");
    idle(16'h3000, 16'h3000, 4'h9, "t2 c3");
  endtask

  task automatic t_stretch;  // R3/R4 null patterns, R5 odd word
    bus_cyc(1, 0, 3'b001, 16'h4005, 1, 1, 0, 4'h6, 16'h1122, 16'h4005, 1, 16'h4005, 3'b001, 4'h0, "t3 c1");
    bus_cyc(1, 1, 3'b001, 16'h4005, 1, 1, 0, 4'h6, 16'h1122, 16'h4005, 1, 16'h2211, 3'b000, 4'h6, "t3 c2");
    bus_cyc(1, 1, 3'b001, 16'h4005, 1, 1, 0, 4'h6, 16'h1122, 16'h4005, 1, 16'h4005, 3'b000, 4'h0, "t3 c3");
    idle(16'h4005, 16'h4005, 4'h0, "t3 c4");
  endtask

  task automatic t_byte_even;  // R5 even byte
    bus_cyc(1, 0, 3'b001, 16'h8002, 0, 1, 0, 4'h1, 16'h00C3, 16'h8002, 1, 16'h8002, 3'b001, 4'h0, "t4 c1");
    idle(16'h8002, 16'hC302, 4'h1, "t4 c2");
  endtask

  task automatic t_coproc;  // R6 non-CPU read
    bus_cyc(1, 0, 3'b011, 16'h5000, 1, 1, 0, 4'h7, 16'hFFFF, 16'h5000, 1, 16'h5000, 3'b011, 4'h0, "t5 c1");
    idle(16'h5000, 16'h5000, 4'h7, "t5 c2");
  endtask

  task automatic t_fw;  // R7
    bus_cyc(1, 0, 3'b001, 16'h6002, 1, 0, 1, 4'hA, 16'h0000, 16'h6002, 1, 16'h6002, 3'b001, 4'h0, "t6 c1");
    idle(16'h6002, 16'h6002, 4'h0, "t6 c2");
  endtask

  task automatic t_cont_after_idle;  // R9, R6 debug read
    bus_cyc(1, 1, 3'b010, 16'h7000, 1, 1, 0, 4'h2, 16'h1234, 16'h7000, 1, 16'h7000, 3'b010, 4'h0, "t7 c1 R9");
    idle(16'h7000, 16'h7000, 4'h2, "t7 c2 R9");
  endtask

  task automatic t_error;  // R3 error code, R6
    bus_cyc(1, 0, 3'b101, 16'h9000, 1, 1, 0, 4'h4, 16'h5555, 16'h9000, 1, 16'h9000, 3'b101, 4'h0, "t8 c1");
    idle(16'h9000, 16'h9000, 4'h4, "t8 c2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word_even();
    t_byte_odd_write();
    t_stretch();
    t_byte_even();
    t_coproc();
    t_fw();
    t_cont_after_idle();
    t_error();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule